// File: doc/BRIEF.md
# Protected Kernel Mode Supervisor

This block sits beside a small signal-processing core and watches two streams: the program fetches (address, program overlay and the reason for the fetch) and the data accesses (address, data overlay and a strobe). From these it keeps a mode state machine that decides whether the core is running trusted kernel code or ordinary user code. The only way into kernel mode is a fetch of a single fixed gate address in a single fixed overlay. Any user-level touch of protected program or data space, any illegal return, and any interrupt that would nest too deeply ends in an immediate erase-and-reset pulse. There is no recoverable fault trap.

While the kernel runs, emulator bus requests are refused. Interrupts are gated off whenever the kernel marks a sensitive window. An interrupt taken in kernel mode suspends the kernel, and the block records where it was interrupted. The matching return has to come back to exactly that point. From inside such an interrupt handler, one further kernel entry is permitted, which gives a nesting depth of two. The erase engine, the interrupt controller and the memories live elsewhere and see only the outputs listed below.

Top module: `kms_supervisor`

## Requirements
- R1: After reset the block is in user mode: `kernel_mode` is 0, `nest_depth` is 0, and `viol_reset` and `erase_req` are 0.
- R2: When `kernel_mode` is 0, a program fetch to an address from 0x2001 to 0x3FFF with a program overlay from 0xC to 0xF raises `viol_reset` and `erase_req` together, in the cycle after the fetch, for one clock. A fetch outside either range raises nothing.
- R3: When `kernel_mode` is 0, a data access to an address at or below 0x17FF, or a data access with data overlay 0xF, raises the same one-clock violation pulse in the next cycle.
- R4: `fetch_cause` is encoded as 0 = sequential, 1 = branch or call, 2 = interrupt vector, 3 = return from interrupt. From depth 0, a fetch of address 0x2000 with overlay 0xF and cause 0 or 1 sets `kernel_mode` to 1 and `nest_depth` to 1 in the next cycle. The same pair fetched with cause 2 or 3 does not enter kernel mode.
- R5: In kernel mode, a fetch with cause 0, 1 or 3 that lies outside kernel program space leaves kernel mode without a violation. Kernel program space is address 0x2000 to 0x3FFF with overlay 0xC to 0xF. From depth 1 the exit goes to depth 0. From depth 2 it goes back to the suspended handler at depth 1.
- R6: `emu_grant` equals `emu_req` while `kernel_mode` is 0, and is 0 while `kernel_mode` is 1.
- R7: `irq_enable` is 0 while `sens_window` is 1, and is 1 otherwise.
- R8: An interrupt vector fetch at depth 1 in kernel mode suspends the kernel (`kernel_mode` 0, `nest_depth` 1) and saves the address and overlay of the last fetch made at depth 1 in kernel mode. The handler's return (cause 3) must fetch exactly that pair. If it does, kernel mode resumes at depth 1. If it does not, a violation follows.
- R9: A kernel entry made from the suspended-handler state gives `nest_depth` 2 with `kernel_mode` 1. At depth 2, an interrupt vector fetch outside kernel program space is a violation. A vector fetch inside that space keeps depth 2.
- R10: In the cycle where the violation pulse is high, `kernel_mode` and `nest_depth` are already 0. A violation in the same cycle as a gate fetch wins, so no entry happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A program fetch happens this cycle |
| fetch_addr | input | 14 | Program fetch address |
| fetch_ovl | input | 4 | Program overlay value of the fetch |
| fetch_cause | input | 2 | Why the fetch happens (see R4) |
| data_valid | input | 1 | A data access happens this cycle |
| data_addr | input | 14 | Data access address |
| data_ovl | input | 4 | Data overlay value of the access |
| sens_window | input | 1 | Kernel marks a sensitive section |
| emu_req | input | 1 | Emulator asks for the bus |
| kernel_mode | output | 1 | The core is executing trusted kernel code |
| viol_reset | output | 1 | One-clock chip reset after a violation |
| erase_req | output | 1 | Request to wipe sensitive state, paired with the reset |
| irq_enable | output | 1 | Interrupt acceptance gate |
| emu_grant | output | 1 | Emulator bus grant |
| nest_depth | output | 2 | 0 user, 1 kernel or its suspended handler, 2 nested kernel |

## Verification
The assertions assume the following about the inputs:
- Fetch and data inputs are stable across the sampling edge.
- A handler runs entirely in user space, and while a handler is still outstanding at depth 1 no second interrupt vector arrives.
- `fetch_cause` only carries its four defined codes.

The stimulus keeps to these assumptions. It drives every input on the falling edge, takes interrupts only from depth-1 kernel code or at depth 2, and never stacks handlers. Within those limits it walks every mode change, the range edges at 0x2000, 0x2001, 0x3FFF, 0x17FF and 0x1800, and same-cycle conflicts between entry and a violation.

// File: rtl/kms_pkg.sv
package kms_pkg;

   typedef enum logic [1:0] {
      FC_SEQ    = 2'd0,
      FC_BRANCH = 2'd1,
      FC_VECTOR = 2'd2,
      FC_RETURN = 2'd3
   } fetch_cause_e;

   typedef enum logic [1:0] {
      ST_USER   = 2'd0,
      ST_KERNEL = 2'd1,
      ST_ISR    = 2'd2,
      ST_NESTED = 2'd3
   } kmode_e;

endpackage

// File: rtl/kms_space_decode.sv
module kms_space_decode #(
   parameter int unsigned AW          = 14,
   parameter int unsigned OW          = 4,
   parameter int unsigned GATE_ADDR   = 'h2000,
   parameter int unsigned GATE_OVL    = 'hF,
   parameter int unsigned PM_TOP      = 'h3FFF,
   parameter int unsigned PM_OVL_LO   = 'hC,
   parameter int unsigned PM_OVL_HI   = 'hF,
   parameter int unsigned DM_TOP      = 'h17FF,
   parameter int unsigned DM_OVL_LOCK = 'hF
) (
   input  logic [AW-1:0] fetch_addr,
   input  logic [OW-1:0] fetch_ovl,
   input  logic [AW-1:0] data_addr,
   input  logic [OW-1:0] data_ovl,
   output logic          gate_hit,
   output logic          pm_kspace,
   output logic          pm_guarded,
   output logic          dm_guarded
);
   localparam logic [AW-1:0] GATE_A  = AW'(GATE_ADDR);
   localparam logic [AW-1:0] GUARD_A = AW'(GATE_ADDR + 1);
   localparam logic [AW-1:0] PM_T    = AW'(PM_TOP);
   localparam logic [AW-1:0] DM_T    = AW'(DM_TOP);
   localparam logic [OW-1:0] GATE_O  = OW'(GATE_OVL);
   localparam logic [OW-1:0] OVL_LO  = OW'(PM_OVL_LO);
   localparam logic [OW-1:0] OVL_HI  = OW'(PM_OVL_HI);
   localparam logic [OW-1:0] DM_LOCK = OW'(DM_OVL_LOCK);

   if (PM_TOP <= GATE_ADDR) begin : g_bad_pm_range
      $error("kms_space_decode: PM_TOP must lie above GATE_ADDR");
   end
   if (PM_OVL_LO > PM_OVL_HI) begin : g_bad_ovl_range
      $error("kms_space_decode: overlay range is empty");
   end

   logic ovl_in;
   assign ovl_in     = (fetch_ovl >= OVL_LO) && (fetch_ovl <= OVL_HI);
   assign gate_hit   = (fetch_addr == GATE_A) && (fetch_ovl == GATE_O);
   assign pm_kspace  = ovl_in && (fetch_addr >= GATE_A)  && (fetch_addr <= PM_T);
   assign pm_guarded = ovl_in && (fetch_addr >= GUARD_A) && (fetch_addr <= PM_T);
   assign dm_guarded = (data_addr <= DM_T) || (data_ovl == DM_LOCK);

endmodule

// File: rtl/kms_ret_ctx.sv
module kms_ret_ctx #(
   parameter int unsigned AW = 14,
   parameter int unsigned OW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          track_en,
   input  logic          save_en,
   input  logic [AW-1:0] fetch_addr,
   input  logic [OW-1:0] fetch_ovl,
   output logic          ret_match
);
   logic [AW-1:0] last_addr, saved_addr;
   logic [OW-1:0] last_ovl,  saved_ovl;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         last_addr  <= '0;
         last_ovl   <= '0;
         saved_addr <= '0;
         saved_ovl  <= '0;
      end else begin
         if (track_en) begin
            last_addr <= fetch_addr;
            last_ovl  <= fetch_ovl;
         end
         if (save_en) begin
            saved_addr <= last_addr;
            saved_ovl  <= last_ovl;
         end
      end
   end

   assign ret_match = (fetch_addr == saved_addr) && (fetch_ovl == saved_ovl);

   // R8: the saved pair only moves when an interrupt suspends the kernel
   a_r8_saved_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(save_en) && !$past(clr)) |-> ($stable(saved_addr) && $stable(saved_ovl)));

endmodule

// File: rtl/kms_mode_fsm.sv
module kms_mode_fsm
   import kms_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fetch_valid,
   input  logic [1:0] fetch_cause,
   input  logic       data_valid,
   input  logic       gate_hit,
   input  logic       pm_kspace,
   input  logic       pm_guarded,
   input  logic       dm_guarded,
   input  logic       ret_match,
   output logic       kernel_mode,
   output logic [1:0] nest_depth,
   output logic       viol_q,
   output logic       ctx_clr,
   output logic       track_en,
   output logic       save_en
);
   kmode_e       state, state_nx;
   fetch_cause_e cause;
   logic         user_lvl, is_entry, is_vec, is_ret, viol_now;

   assign cause    = fetch_cause_e'(fetch_cause);
   assign user_lvl = (state == ST_USER) || (state == ST_ISR);
   assign is_entry = fetch_valid && gate_hit && (cause == FC_SEQ || cause == FC_BRANCH);
   assign is_vec   = fetch_valid && (cause == FC_VECTOR);
   assign is_ret   = fetch_valid && (cause == FC_RETURN);

   always_comb begin
      viol_now = 1'b0;
      if (user_lvl) begin
         if (data_valid && dm_guarded) viol_now = 1'b1;
         if (fetch_valid && pm_guarded && !(state == ST_ISR && is_ret)) viol_now = 1'b1;
         if (state == ST_ISR && is_ret && !ret_match) viol_now = 1'b1;
      end
      if (state == ST_NESTED && is_vec && !pm_kspace) viol_now = 1'b1;
   end

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_USER:   if (is_entry) state_nx = ST_KERNEL;
         ST_KERNEL: begin
            if (is_vec) state_nx = ST_ISR;
            else if (fetch_valid && !pm_kspace) state_nx = ST_USER;
         end
         ST_ISR: begin
            if (is_ret && ret_match) state_nx = ST_KERNEL;
            else if (is_entry) state_nx = ST_NESTED;
         end
         ST_NESTED: begin
            if (fetch_valid && !is_vec && !pm_kspace) state_nx = ST_ISR;
         end
         default: state_nx = ST_USER;
      endcase
      if (viol_now) state_nx = ST_USER;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_USER;
         viol_q <= 1'b0;
      end else begin
         state  <= state_nx;
         viol_q <= viol_now;
      end
   end

   assign ctx_clr     = viol_now;
   assign track_en    = fetch_valid && !is_vec && !viol_now && (state_nx == ST_KERNEL);
   assign save_en     = (state == ST_KERNEL) && is_vec;
   assign kernel_mode = (state == ST_KERNEL) || (state == ST_NESTED);
   assign nest_depth  = (state == ST_USER)   ? 2'd0 :
                        (state == ST_NESTED) ? 2'd2 : 2'd1;

   // R4: depth-0 to kernel only through the gate pair
   a_r4_gate_only: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_KERNEL && $past(state) == ST_USER) |-> $past(gate_hit && fetch_valid));
   // R8: resume from handler only through a matching return
   a_r8_resume_match: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_KERNEL && $past(state) == ST_ISR) |-> ($past(is_ret) && $past(ret_match)));
   // R9: depth 2 reached only by a gate entry from the handler state
   a_r9_nest_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_NESTED && $past(state) != ST_NESTED) |-> ($past(state) == ST_ISR && $past(gate_hit)));

endmodule

// File: rtl/kms_supervisor.sv
module kms_supervisor #(
   parameter int unsigned AW        = 14,
   parameter int unsigned OW        = 4,
   parameter bit          GRANT_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fetch_valid,
   input  logic [AW-1:0] fetch_addr,
   input  logic [OW-1:0] fetch_ovl,
   input  logic [1:0]    fetch_cause,
   input  logic          data_valid,
   input  logic [AW-1:0] data_addr,
   input  logic [OW-1:0] data_ovl,
   input  logic          sens_window,
   input  logic          emu_req,
   output logic          kernel_mode,
   output logic          viol_reset,
   output logic          erase_req,
   output logic          irq_enable,
   output logic          emu_grant,
   output logic [1:0]    nest_depth
);
   if (AW < 14) begin : g_bad_aw
      $error("kms_supervisor: AW must cover the protected ranges");
   end
   if (OW < 4) begin : g_bad_ow
      $error("kms_supervisor: OW must hold overlay 0xF");
   end

   logic gate_hit, pm_kspace, pm_guarded, dm_guarded;
   logic ret_match, ctx_clr, track_en, save_en, viol_q;

   kms_space_decode #(.AW(AW), .OW(OW)) u_decode (
      .fetch_addr (fetch_addr),
      .fetch_ovl  (fetch_ovl),
      .data_addr  (data_addr),
      .data_ovl   (data_ovl),
      .gate_hit   (gate_hit),
      .pm_kspace  (pm_kspace),
      .pm_guarded (pm_guarded),
      .dm_guarded (dm_guarded)
   );

   kms_ret_ctx #(.AW(AW), .OW(OW)) u_ctx (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (ctx_clr),
      .track_en   (track_en),
      .save_en    (save_en),
      .fetch_addr (fetch_addr),
      .fetch_ovl  (fetch_ovl),
      .ret_match  (ret_match)
   );

   kms_mode_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .fetch_valid (fetch_valid),
      .fetch_cause (fetch_cause),
      .data_valid  (data_valid),
      .gate_hit    (gate_hit),
      .pm_kspace   (pm_kspace),
      .pm_guarded  (pm_guarded),
      .dm_guarded  (dm_guarded),
      .ret_match   (ret_match),
      .kernel_mode (kernel_mode),
      .nest_depth  (nest_depth),
      .viol_q      (viol_q),
      .ctx_clr     (ctx_clr),
      .track_en    (track_en),
      .save_en     (save_en)
   );

   assign viol_reset = viol_q;
   assign erase_req  = viol_q;
   assign irq_enable = !sens_window;

   if (GRANT_REG) begin : g_grant_reg
      logic grant_q;
      always_ff @(posedge clk) begin
         if (!rst_n) grant_q <= 1'b0;
         else        grant_q <= emu_req && !kernel_mode;
      end
      assign emu_grant = grant_q;
   end else begin : g_grant_comb
      assign emu_grant = emu_req && !kernel_mode;
      // R6: no grant while kernel code runs
      a_r6_no_grant_kernel: assert property (@(posedge clk) disable iff (!rst_n)
         kernel_mode |-> !emu_grant);
   end

   // R10: the reset pulse lands with mode state already cleared
   a_r10_pulse_clears: assert property (@(posedge clk) disable iff (!rst_n)
      viol_reset |-> (!kernel_mode && nest_depth == 2'd0));
   // R9: depth never exceeds two, and depth 2 implies kernel mode
   a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (nest_depth == 2'd2) |-> kernel_mode);

endmodule

// File: tb/kms_supervisor_bench.sv
module kms_supervisor_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_valid = 1'b0;
   logic [13:0] fetch_addr = '0;
   logic [3:0]  fetch_ovl = '0;
   logic [1:0]  fetch_cause = '0;
   logic        data_valid = 1'b0;
   logic [13:0] data_addr = 14'h3000;
   logic [3:0]  data_ovl = '0;
   logic        sens_window = 1'b0;
   logic        emu_req = 1'b0;
   logic        kernel_mode, viol_reset, erase_req, irq_enable, emu_grant;
   logic [1:0]  nest_depth;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   kms_supervisor u_kms_supervisor (
      .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
      .fetch_ovl(fetch_ovl), .fetch_cause(fetch_cause), .data_valid(data_valid),
      .data_addr(data_addr), .data_ovl(data_ovl), .sens_window(sens_window),
      .emu_req(emu_req), .kernel_mode(kernel_mode), .viol_reset(viol_reset),
      .erase_req(erase_req), .irq_enable(irq_enable), .emu_grant(emu_grant),
      .nest_depth(nest_depth)
   );

   // reference model: 0 user, 1 kernel, 2 suspended handler, 3 nested kernel
   int m_mode = 0;
   int m_viol = 0;
   int m_last_a = 0, m_last_o = 0, m_sav_a = 0, m_sav_o = 0;

   function automatic bit kspace(int a, int o);
      return (a >= 'h2000) && (a <= 'h3FFF) && (o >= 'hC) && (o <= 'hF);
   endfunction

   always @(posedge clk) begin
      int a, o, c, nm;
      bit bad, ent;
      a = fetch_addr; o = fetch_ovl; c = fetch_cause;
      nm = m_mode; bad = 0;
      ent = fetch_valid && a == 'h2000 && o == 'hF && c <= 1;
      if (!rst_n) begin
         m_mode = 0; m_viol = 0; m_last_a = 0; m_last_o = 0; m_sav_a = 0; m_sav_o = 0;
      end else begin
         if (m_mode == 0 || m_mode == 2) begin
            if (data_valid && (data_addr <= 'h17FF || data_ovl == 'hF)) bad = 1;
            if (fetch_valid && kspace(a, o) && a != 'h2000 && !(m_mode == 2 && c == 3)) bad = 1;
            if (m_mode == 2 && fetch_valid && c == 3 && !(a == m_sav_a && o == m_sav_o)) bad = 1;
         end
         if (m_mode == 3 && fetch_valid && c == 2 && !kspace(a, o)) bad = 1;
         case (m_mode)
            0: if (ent) nm = 1;
            1: if (fetch_valid && c == 2) begin
                  nm = 2; m_sav_a = m_last_a; m_sav_o = m_last_o;
               end else if (fetch_valid && !kspace(a, o)) nm = 0;
            2: if (fetch_valid && c == 3 && a == m_sav_a && o == m_sav_o) nm = 1;
               else if (ent) nm = 3;
            default: if (fetch_valid && c != 2 && !kspace(a, o)) nm = 2;
         endcase
         if (bad) begin
            nm = 0; m_last_a = 0; m_last_o = 0; m_sav_a = 0; m_sav_o = 0;
         end else if (fetch_valid && c != 2 && nm == 1) begin
            m_last_a = a; m_last_o = o;
         end
         m_mode = nm;
         m_viol = bad;
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_cmp();
      int km, dp;
      km = (m_mode == 1 || m_mode == 3);
      dp = (m_mode == 0) ? 0 : (m_mode == 3) ? 2 : 1;
      chk("R4 model kernel_mode", kernel_mode, km);
      chk("R9 model nest_depth", nest_depth, dp);
      chk("R2 model viol_reset", viol_reset, m_viol);
      chk("R3 model erase_req", erase_req, m_viol);
      chk("R7 model irq_enable", irq_enable, !sens_window);
      chk("R6 model emu_grant", emu_grant, emu_req && !km);
   endtask

   task automatic step(bit fv, int fa, int fo, int fc, bit dv, int da, int dov, bit sw, bit er);
      @(negedge clk);
      if (rst_n) model_cmp();
      fetch_valid = fv; fetch_addr = 14'(fa); fetch_ovl = 4'(fo); fetch_cause = 2'(fc);
      data_valid = dv; data_addr = 14'(da); data_ovl = 4'(dov);
      sens_window = sw; emu_req = er;
   endtask

   task automatic fetch(int fa, int fo, int fc);
      step(1, fa, fo, fc, 0, 'h3000, 0, 0, 0);
   endtask
   task automatic data(int da, int dov);
      step(0, 0, 0, 0, 1, da, dov, 0, 0);
   endtask
   task automatic idle();
      step(0, 0, 0, 0, 0, 'h3000, 0, 0, 0);
   endtask
   task automatic post();
      @(posedge clk); #1;
   endtask
   task automatic expect_st(string tag, int km, int dp, int vr);
      chk({tag, " kernel_mode"}, kernel_mode, km);
      chk({tag, " nest_depth"}, nest_depth, dp);
      chk({tag, " viol_reset"}, viol_reset, vr);
      chk({tag, " erase_req"}, erase_req, vr);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      emu_req = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      post();
      expect_st("R1 reset", 0, 0, 0);
      chk("R1 grant after reset", emu_grant, 1);

      // R4 entry by branch; R6 grant drops
      step(1, 'h2000, 'hF, 1, 0, 'h3000, 0, 0, 1); post();
      expect_st("R4 branch entry", 1, 1, 0);
      chk("R6 no grant in kernel", emu_grant, 0);
      fetch('h2001, 'hF, 0); post();
      expect_st("R2 kernel may fetch guarded", 1, 1, 0);
      // R7 gate
      step(0, 0, 0, 0, 0, 'h3000, 0, 1, 0); post();
      chk("R7 window closes irq", irq_enable, 0);
      idle(); post();
      chk("R7 window open", irq_enable, 1);
      // R8 bad return
      fetch('h0040, 0, 2); post();
      expect_st("R8 suspended", 0, 1, 0);
      fetch('h2002, 'hF, 3); post();
      expect_st("R8 wrong return", 0, 0, 1);
      idle(); post();
      expect_st("R2 pulse one clock", 0, 0, 0);
      // R8 good return
      fetch('h2000, 'hF, 0); post();
      expect_st("R4 sequential entry", 1, 1, 0);
      fetch('h2100, 'hC, 1); post();
      expect_st("R5 stays in kernel space", 1, 1, 0);
      fetch('h0040, 0, 2); post();
      expect_st("R8 suspended again", 0, 1, 0);
      data('h0000, 0); post();
      expect_st("R3 handler data guarded", 0, 0, 1);
      fetch('h2000, 'hF, 1); fetch('h2100, 'hC, 0); fetch('h0040, 0, 2);
      fetch('h2100, 'hC, 3); post();
      expect_st("R8 matching return", 1, 1, 0);
      // R5 exit
      fetch('h0100, 0, 1); post();
      expect_st("R5 exit to user", 0, 0, 0);
      // R2 boundaries
      fetch('h2001, 'hB, 0); post();
      expect_st("R2 overlay 0xB free", 0, 0, 0);
      fetch('h4000 & 'h3FFF, 'hF, 0); post();
      expect_st("R2 address 0x0000 pm free", 0, 0, 0);
      fetch('h3FFF, 'hC, 0); post();
      expect_st("R2 top of guarded", 0, 0, 1);
      // R3 boundaries
      data('h1800, 0); post();
      expect_st("R3 0x1800 free", 0, 0, 0);
      data('h17FF, 0); post();
      expect_st("R3 0x17FF guarded", 0, 0, 1);
      data('h3000, 'hF); post();
      expect_st("R3 overlay 0xF guarded", 0, 0, 1);
      // R4 negatives
      fetch('h2000, 'hF, 2); post();
      expect_st("R4 vector no entry", 0, 0, 0);
      fetch('h2000, 'hF, 3); post();
      expect_st("R4 return no entry", 0, 0, 0);
      fetch('h2000, 'hE, 1); post();
      expect_st("R4 wrong overlay", 0, 0, 0);
      // R9 nesting
      fetch('h2000, 'hF, 1); fetch('h0040, 0, 2); fetch('h2000, 'hF, 1); post();
      expect_st("R9 nested entry", 1, 2, 0);
      fetch('h2300, 'hF, 2); post();
      expect_st("R9 kernel vector ok", 1, 2, 0);
      fetch('h0200, 0, 1); post();
      expect_st("R5 nested exit", 0, 1, 0);
      fetch('h2000, 'hF, 1); post();
      expect_st("R9 re-nest", 1, 2, 0);
      fetch('h0050, 0, 2); post();
      expect_st("R9 user vector in nest", 0, 0, 1);
      // R10 violation beats entry
      step(1, 'h2000, 'hF, 1, 1, 'h0010, 0, 0, 0); post();
      expect_st("R10 violation wins", 0, 0, 1);
      step(0, 0, 0, 0, 0, 'h3000, 0, 0, 1); post();
      chk("R6 grant in user", emu_grant, 1);
      idle(); idle();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule